// File: doc/BRIEF.md
# Serial Configuration Sequencer for a Downstream Programmable Device

This block runs the serial bring-up of a programmable device that sits beside the chip. When `start_i` is pulsed it pulls the active-low configuration request line low for a set number of cycles and expects the device's active-low status line to follow it. It then releases the request, waits a settle interval, and polls until the device lets go of its status line. After that it takes bitstream bytes from an upstream stream and shifts them out on a serial data/clock pair. Each byte goes out least-significant bit first, and the device samples on the rising clock edge. Once the byte marked last has gone out, the sequencer requires the device's configuration-done input to be high. It then issues a fixed run of trailing clock pulses and raises `done_o`.

Any failed step ends the sequence. `fail_o` rises and `err_o` carries the reason, and every line toward the device goes back to its idle level. All intervals are parameters counted in system-clock cycles. The serial clock half-period is also a parameter, which keeps the serial rate inside what the device accepts. Both device inputs pass through a two-stage synchroniser before any decision uses them.

The byte stream follows valid/ready rules. A byte moves on a clock edge where `s_valid_i` and `s_ready_o` are both high. `s_ready_o` is high only while the load phase is active, no byte is being shifted, and the byte marked last has not yet been taken. Upstream may hold `s_valid_i` for as long as it likes. The byte, its last flag and valid must stay stable until the handshake.

Top module: `pscfg_master`

## Requirements
- R1: A `start_i` pulse seen while no sequence runs drives `cfg_req_n_o` low for exactly REQ_HOLD_CYC cycles. A `start_i` pulse while a sequence runs is ignored.
- R2: If the synchronised `stat_n_i` is not low at the end of the request hold, the sequence fails with `err_o` = 1 and no byte is accepted.
- R3: After the request is released the block waits REL_WAIT_CYC cycles and then polls `stat_n_i` for up to RLS_TIMEOUT_CYC cycles. If `stat_n_i` is still low when that window ends, the sequence fails with `err_o` = 2. `fail_o` therefore rises REQ_HOLD_CYC+REL_WAIT_CYC+RLS_TIMEOUT_CYC cycles after the start edge.
- R4: Bytes are accepted only after the status line has been released, one per completed byte. After the byte flagged by `s_last_i` is accepted, no further byte is taken in that sequence.
- R5: Each byte is sent bit 0 first. Each bit is set on `cfg_data_o` while `cfg_clk_o` is low, `cfg_clk_o` then stays high for HALF_CYC cycles, and `cfg_data_o` is stable while the clock is high.
- R6: After the last byte, if the synchronised `cfg_done_i` is low, the sequence fails with `err_o` = 3 and no trailing pulses are issued.
- R7: On success exactly TRAIL_PULSES further clock pulses follow, each high for HALF_CYC cycles then low for HALF_CYC cycles. Then `done_o` rises with `err_o` = 0, so a run of N bytes shows 8·N+TRAIL_PULSES rising clock edges.
- R8: After a failure `fail_o` is high, `done_o` is low, `cfg_req_n_o` is high, and `cfg_clk_o` and `cfg_data_o` are low. `done_o`, `fail_o` and `err_o` hold until the next accepted start, which clears them. The error codes are 0 none, 1 status never asserted, 2 status release timeout, 3 configuration-done missing.
- R9: After reset `cfg_req_n_o` is 1. `cfg_clk_o`, `cfg_data_o`, `s_ready_o`, `done_o`, `fail_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a configuration sequence (one-cycle pulse) |
| s_valid_i | input | 1 | Upstream byte valid |
| s_data_i | input | BYTE_W | Upstream bitstream byte |
| s_last_i | input | 1 | Marks the final byte of the bitstream |
| s_ready_o | output | 1 | Block can take a byte this cycle |
| stat_n_i | input | 1 | Device status line, active low, asynchronous |
| cfg_done_i | input | 1 | Device configuration-done line, active high, asynchronous |
| cfg_req_n_o | output | 1 | Configuration request to the device, active low |
| cfg_clk_o | output | 1 | Serial configuration clock |
| cfg_data_o | output | 1 | Serial configuration data |
| done_o | output | 1 | Last sequence completed successfully |
| fail_o | output | 1 | Last sequence aborted |
| err_o | output | 2 | Abort reason code |

## Verification
The abort paths are the hardest part to reach, because a well-behaved device never produces them. The bench therefore models the device with selectable misbehaviours. It can ignore the request, hold its status line low forever, or never raise configuration-done, and each mode drives one abort path with exact cycle timing. A second hard corner is a byte offered right after the last one while trailing pulses run, together with start pulses landing mid-sequence. The bench holds valid high with a spare byte and pulses start during the request and load phases. It then checks that the handshake count and the request-low time are unchanged.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_SETTLE,
    ST_POLL,
    ST_LOAD,
    ST_CHECK,
    ST_TRAIL
  } seq_st_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_NOSTAT  = 2'd1,
    ERR_TIMEOUT = 2'd2,
    ERR_NODONE  = 2'd3
  } err_e;
endpackage

// File: rtl/pscfg_sync.sv
module pscfg_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ff <= {STAGES{RST_VAL[g]}};
      else        ff <= {ff[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = ff[STAGES-1];
  end
endmodule

// File: rtl/pscfg_seq.sv
module pscfg_seq
  import pscfg_pkg::*;
#(
  parameter int REQ_HOLD_CYC    = 250,
  parameter int REL_WAIT_CYC    = 250,
  parameter int RLS_TIMEOUT_CYC = 12_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       stat_low_i,
  input  logic       dev_done_i,
  input  logic       last_sent_i,
  input  logic       trail_done_i,
  output logic       cfg_req_n_o,
  output logic       shift_en_o,
  output logic       trail_go_o,
  output logic       done_o,
  output logic       fail_o,
  output logic [1:0] err_o
);
  localparam int MAX_AB = (REQ_HOLD_CYC > REL_WAIT_CYC) ? REQ_HOLD_CYC : REL_WAIT_CYC;
  localparam int MAX_C  = (MAX_AB > RLS_TIMEOUT_CYC) ? MAX_AB : RLS_TIMEOUT_CYC;
  localparam int TW     = $clog2(MAX_C + 1);

  seq_st_e       st;
  logic [TW-1:0] tmr;
  logic          done_q, fail_q, go_q;
  err_e          err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      tmr    <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      go_q   <= 1'b0;
      err_q  <= ERR_NONE;
    end else begin
      go_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start_i) begin
            st     <= ST_REQ;
            tmr    <= TW'(REQ_HOLD_CYC - 1);
            done_q <= 1'b0;
            fail_q <= 1'b0;
            err_q  <= ERR_NONE;
          end
        end
        ST_REQ: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else if (stat_low_i) begin
            st  <= ST_SETTLE;
            tmr <= TW'(REL_WAIT_CYC - 1);
          end else begin
            st     <= ST_IDLE;
            fail_q <= 1'b1;
            err_q  <= ERR_NOSTAT;
          end
        end
        ST_SETTLE: begin
          if (tmr != '0) begin
            tmr <= tmr - 1'b1;
          end else begin
            st  <= ST_POLL;
            tmr <= TW'(RLS_TIMEOUT_CYC - 1);
          end
        end
        ST_POLL: begin
          if (!stat_low_i) begin
            st <= ST_LOAD;
          end else if (tmr == '0) begin
            st     <= ST_IDLE;
            fail_q <= 1'b1;
            err_q  <= ERR_TIMEOUT;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_LOAD: begin
          if (last_sent_i) st <= ST_CHECK;
        end
        ST_CHECK: begin
          if (dev_done_i) begin
            st   <= ST_TRAIL;
            go_q <= 1'b1;
          end else begin
            st     <= ST_IDLE;
            fail_q <= 1'b1;
            err_q  <= ERR_NODONE;
          end
        end
        ST_TRAIL: begin
          if (trail_done_i) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign cfg_req_n_o = (st != ST_REQ);
  assign shift_en_o  = (st == ST_LOAD);
  assign trail_go_o  = go_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign err_o       = err_q;

  // R1: the request never lasts only a single cycle
  p_req_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_req_n_o) |=> !cfg_req_n_o);

  // R3: bytes flow only once the status release was seen
  p_load_after_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_en_o) |-> !$past(stat_low_i));
endmodule

// File: rtl/pscfg_shift.sv
module pscfg_shift #(
  parameter int BYTE_W       = 8,
  parameter int HALF_CYC     = 2,
  parameter int TRAIL_PULSES = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en_i,
  input  logic              s_valid_i,
  input  logic [BYTE_W-1:0] s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  input  logic              trail_go_i,
  output logic              dclk_o,
  output logic              data_o,
  output logic              last_sent_o,
  output logic              trail_done_o
);
  localparam int HW = $clog2(HALF_CYC + 1);
  localparam int BW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam int PW = $clog2(TRAIL_PULSES + 1);

  logic              busy_q, trail_q, hi_q, dclk_q, last_q, fin_q;
  logic              last_sent_q, trail_done_q;
  logic [HW-1:0]     tmr;
  logic [BW-1:0]     bit_cnt;
  logic [PW-1:0]     pulse_cnt;
  logic [BYTE_W-1:0] shreg;
  logic              take;

  assign s_ready_o = shift_en_i & ~busy_q & ~fin_q;
  assign take      = s_valid_i & s_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q       <= 1'b0;
      trail_q      <= 1'b0;
      hi_q         <= 1'b0;
      dclk_q       <= 1'b0;
      last_q       <= 1'b0;
      fin_q        <= 1'b0;
      last_sent_q  <= 1'b0;
      trail_done_q <= 1'b0;
      tmr          <= '0;
      bit_cnt      <= '0;
      pulse_cnt    <= '0;
      shreg        <= '0;
    end else begin
      last_sent_q  <= 1'b0;
      trail_done_q <= 1'b0;
      if (!shift_en_i) fin_q <= 1'b0;

      if (take) begin
        busy_q  <= 1'b1;
        shreg   <= s_data_i;
        dclk_q  <= 1'b0;
        hi_q    <= 1'b0;
        tmr     <= HW'(HALF_CYC - 1);
        bit_cnt <= '0;
        last_q  <= s_last_i;
        if (s_last_i) fin_q <= 1'b1;
      end else if (busy_q) begin
        if (tmr != '0) begin
          tmr <= tmr - 1'b1;
        end else if (!hi_q) begin
          hi_q   <= 1'b1;
          dclk_q <= 1'b1;
          tmr    <= HW'(HALF_CYC - 1);
        end else if (bit_cnt == BW'(BYTE_W - 1)) begin
          busy_q      <= 1'b0;
          hi_q        <= 1'b0;
          dclk_q      <= 1'b0;
          shreg       <= '0;
          last_sent_q <= last_q;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
          shreg   <= shreg >> 1;
          hi_q    <= 1'b0;
          dclk_q  <= 1'b0;
          tmr     <= HW'(HALF_CYC - 1);
        end
      end else if (trail_go_i) begin
        trail_q   <= 1'b1;
        hi_q      <= 1'b1;
        dclk_q    <= 1'b1;
        tmr       <= HW'(HALF_CYC - 1);
        pulse_cnt <= '0;
      end else if (trail_q) begin
        if (tmr != '0) begin
          tmr <= tmr - 1'b1;
        end else if (hi_q) begin
          hi_q   <= 1'b0;
          dclk_q <= 1'b0;
          tmr    <= HW'(HALF_CYC - 1);
        end else if (pulse_cnt == PW'(TRAIL_PULSES - 1)) begin
          trail_q      <= 1'b0;
          trail_done_q <= 1'b1;
        end else begin
          pulse_cnt <= pulse_cnt + 1'b1;
          hi_q      <= 1'b1;
          dclk_q    <= 1'b1;
          tmr       <= HW'(HALF_CYC - 1);
        end
      end
    end
  end

  assign dclk_o       = dclk_q;
  assign data_o       = shreg[0];
  assign last_sent_o  = last_sent_q;
  assign trail_done_o = trail_done_q;

  // R5: data must not move while the serial clock is high
  p_data_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dclk_o && $past(dclk_o)) |-> $stable(data_o));

  // R4: a byte is never taken while the previous one is still shifting
  p_no_take_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid_i && s_ready_o) |=> (busy_q && !s_ready_o));
endmodule

// File: rtl/pscfg_master.sv
module pscfg_master #(
  parameter int BYTE_W          = 8,
  parameter int REQ_HOLD_CYC    = 250,
  parameter int REL_WAIT_CYC    = 250,
  parameter int RLS_TIMEOUT_CYC = 12_500_000,
  parameter int HALF_CYC        = 2,
  parameter int TRAIL_PULSES    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              s_valid_i,
  input  logic [BYTE_W-1:0] s_data_i,
  input  logic              s_last_i,
  output logic              s_ready_o,
  input  logic              stat_n_i,
  input  logic              cfg_done_i,
  output logic              cfg_req_n_o,
  output logic              cfg_clk_o,
  output logic              cfg_data_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [1:0]        err_o
);
  logic [1:0] dev_raw, dev_sync;
  logic       stat_low, dev_done;
  logic       shift_en, trail_go, last_sent, trail_done;

  assign dev_raw = {stat_n_i, cfg_done_i};

  pscfg_sync #(.W(2), .STAGES(2), .RST_VAL(2'b10)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (dev_raw),
    .q_o   (dev_sync)
  );

  assign stat_low = ~dev_sync[1];
  assign dev_done = dev_sync[0];

  pscfg_seq #(
    .REQ_HOLD_CYC    (REQ_HOLD_CYC),
    .REL_WAIT_CYC    (REL_WAIT_CYC),
    .RLS_TIMEOUT_CYC (RLS_TIMEOUT_CYC)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stat_low_i   (stat_low),
    .dev_done_i   (dev_done),
    .last_sent_i  (last_sent),
    .trail_done_i (trail_done),
    .cfg_req_n_o  (cfg_req_n_o),
    .shift_en_o   (shift_en),
    .trail_go_o   (trail_go),
    .done_o       (done_o),
    .fail_o       (fail_o),
    .err_o        (err_o)
  );

  pscfg_shift #(
    .BYTE_W       (BYTE_W),
    .HALF_CYC     (HALF_CYC),
    .TRAIL_PULSES (TRAIL_PULSES)
  ) u_shift (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_en_i   (shift_en),
    .s_valid_i    (s_valid_i),
    .s_data_i     (s_data_i),
    .s_last_i     (s_last_i),
    .s_ready_o    (s_ready_o),
    .trail_go_i   (trail_go),
    .dclk_o       (cfg_clk_o),
    .data_o       (cfg_data_o),
    .last_sent_o  (last_sent),
    .trail_done_o (trail_done)
  );

  // R8: on abort every device-facing line is back at idle
  p_idle_on_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_o) |-> (cfg_req_n_o && !cfg_clk_o && !cfg_data_o));

  // R8: a nonzero reason only accompanies a failure
  p_err_needs_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o != 2'd0) |-> fail_o);

  // R7: success and failure never show together
  p_done_fail_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && fail_o));

  // R4: the stream is closed whenever a result is on display
  p_ready_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> (!done_o && !fail_o && cfg_req_n_o));
endmodule

// File: tb/test_pscfg_master.sv
module test_pscfg_master;
  localparam int RQ  = 8;
  localparam int RW  = 6;
  localparam int TO  = 40;
  localparam int HF  = 2;
  localparam int TP  = 12;
  localparam int RLS = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       s_valid_i = 1'b0;
  logic [7:0] s_data_i = 8'h00;
  logic       s_last_i = 1'b0;
  logic       s_ready_o;
  logic       stat_n_i = 1'b1;
  logic       cfg_done_i = 1'b0;
  logic       cfg_req_n_o, cfg_clk_o, cfg_data_o, done_o, fail_o;
  logic [1:0] err_o;

  int checks = 0;
  int errors = 0;
  int stat_mode = 0;   // 0 well-behaved, 1 never asserts, 2 never releases
  int rls_cnt = 0;

  int req_low_tot = 0;
  int rise_tot = 0;
  int hs_tot = 0;
  int bad_hi_tot = 0;
  int hi_run = 0;
  logic bits [256];
  logic [7:0] pay [8];

  always #4 clk = ~clk;

  pscfg_master #(
    .BYTE_W(8), .REQ_HOLD_CYC(RQ), .REL_WAIT_CYC(RW),
    .RLS_TIMEOUT_CYC(TO), .HALF_CYC(HF), .TRAIL_PULSES(TP)
  ) i_pscfg_master (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .s_valid_i(s_valid_i), .s_data_i(s_data_i), .s_last_i(s_last_i),
    .s_ready_o(s_ready_o), .stat_n_i(stat_n_i), .cfg_done_i(cfg_done_i),
    .cfg_req_n_o(cfg_req_n_o), .cfg_clk_o(cfg_clk_o), .cfg_data_o(cfg_data_o),
    .done_o(done_o), .fail_o(fail_o), .err_o(err_o)
  );

  // device model and monitors
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cfg_req_n_o) begin
        stat_n_i = (stat_mode == 1);
        rls_cnt  = 0;
        req_low_tot++;
      end else if (!stat_n_i && stat_mode == 0) begin
        if (rls_cnt == RLS) stat_n_i = 1'b1;
        else rls_cnt++;
      end
      if (s_valid_i && s_ready_o) hs_tot++;
      if (cfg_clk_o) hi_run++;
      else if (hi_run != 0) begin
        if (hi_run != HF) bad_hi_tot++;
        hi_run = 0;
      end
    end
  end

  always @(posedge cfg_clk_o) begin
    bits[rise_tot % 256] = cfg_data_o;
    rise_tot++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
  endtask

  task automatic feed(input int n, input int gap);
    for (int b = 0; b < n; b++) begin
      @(posedge clk); #1;
      s_valid_i = 1'b1; s_data_i = pay[b]; s_last_i = (b == n - 1);
      do @(negedge clk); while (!s_ready_o);
      @(posedge clk); #1;
      s_valid_i = 1'b0; s_last_i = 1'b0;
      repeat (gap) @(posedge clk);
    end
  endtask

  task automatic wait_end();
    int c = 0;
    while (!(done_o || fail_o) && c < 5000) begin
      @(negedge clk); c++;
    end
  endtask

  task automatic run_ok(input int n, input int gap, input string tag);
    int rq0, rs0, hs0, bh0, mism;
    rq0 = req_low_tot; rs0 = rise_tot; hs0 = hs_tot; bh0 = bad_hi_tot;
    stat_mode = 0; cfg_done_i = 1'b1;
    pulse_start();
    @(negedge clk);
    chk({tag, " R8 start clears done"}, done_o, 0);
    feed(n, gap);
    wait_end();
    @(negedge clk);
    chk({tag, " R7 done"}, done_o, 1);
    chk({tag, " R7 err"}, err_o, 0);
    chk({tag, " R1 request width"}, req_low_tot - rq0, RQ);
    chk({tag, " R7 rising edges"}, rise_tot - rs0, 8 * n + TP);
    chk({tag, " R4 handshakes"}, hs_tot - hs0, n);
    chk({tag, " R5 high width"}, bad_hi_tot - bh0, 0);
    mism = 0;
    for (int b = 0; b < n; b++)
      for (int i = 0; i < 8; i++)
        if (bits[(rs0 + b * 8 + i) % 256] !== pay[b][i]) mism++;
    chk({tag, " R5 LSB-first bits"}, mism, 0);
  endtask

  task automatic t_reset();
    chk("R9 req_n", cfg_req_n_o, 1);
    chk("R9 clk", cfg_clk_o, 0);
    chk("R9 data", cfg_data_o, 0);
    chk("R9 ready", s_ready_o, 0);
    chk("R9 done", done_o, 0);
    chk("R9 fail", fail_o, 0);
    chk("R9 err", err_o, 0);
  endtask

  task automatic t_basic();
    pay[0] = 8'hA5; pay[1] = 8'h3C; pay[2] = 8'h01;
    run_ok(3, 0, "basic");
  endtask

  task automatic t_gaps_extra();
    int hs0, rs0;
    pay[0] = 8'h80; pay[1] = 8'hFF; pay[2] = 8'h00; pay[3] = 8'h6E;
    hs0 = hs_tot; rs0 = rise_tot;
    stat_mode = 0; cfg_done_i = 1'b1;
    pulse_start();
    feed(4, 7);
    // spare byte offered after last must not be taken (R4)
    @(posedge clk); #1 s_valid_i = 1'b1; s_data_i = 8'hEE;
    wait_end();
    @(negedge clk);
    chk("gaps R4 spare byte ignored", hs_tot - hs0, 4);
    chk("gaps R7 rising edges", rise_tot - rs0, 8 * 4 + TP);
    chk("gaps R7 done", done_o, 1);
    @(posedge clk); #1 s_valid_i = 1'b0;
  endtask

  task automatic t_start_ignored();
    int rq0, rs0;
    pay[0] = 8'h5A; pay[1] = 8'hC3;
    rq0 = req_low_tot; rs0 = rise_tot;
    stat_mode = 0; cfg_done_i = 1'b1;
    pulse_start();
    repeat (2) @(posedge clk);
    pulse_start();                       // during request hold (R1)
    fork
      feed(2, 0);
      begin repeat (RQ + RW + 12) @(posedge clk); pulse_start(); end
    join
    wait_end();
    @(negedge clk);
    chk("restart R1 request width", req_low_tot - rq0, RQ);
    chk("restart R7 rising edges", rise_tot - rs0, 8 * 2 + TP);
    chk("restart R7 done", done_o, 1);
  endtask

  task automatic t_nostat();
    int rq0, rs0, hs0;
    rq0 = req_low_tot; rs0 = rise_tot; hs0 = hs_tot;
    stat_mode = 1;
    pulse_start();
    @(posedge clk); #1 s_valid_i = 1'b1; s_data_i = 8'h33; s_last_i = 1'b1;
    wait_end();
    @(negedge clk);
    chk("nostat R2 fail", fail_o, 1);
    chk("nostat R2 err", err_o, 1);
    chk("nostat R2 no byte", hs_tot - hs0, 0);
    chk("nostat R1 request width", req_low_tot - rq0, RQ);
    chk("nostat R8 done low", done_o, 0);
    chk("nostat R8 req idle", cfg_req_n_o, 1);
    chk("nostat R8 clk idle", cfg_clk_o, 0);
    chk("nostat R8 no clocks", rise_tot - rs0, 0);
    @(posedge clk); #1 s_valid_i = 1'b0; s_last_i = 1'b0;
    stat_mode = 0;
  endtask

  task automatic t_timeout();
    int c, hs0;
    hs0 = hs_tot;
    stat_mode = 2;
    @(posedge clk); #1 start_i = 1'b1;
    @(posedge clk); #1 start_i = 1'b0;
    s_valid_i = 1'b1; s_data_i = 8'h44;
    c = 0;
    while (c < 2000) begin
      @(negedge clk);
      if (fail_o) break;
      c++;
    end
    chk("timeout R3 cycles to fail", c, RQ + RW + TO);
    chk("timeout R3 err", err_o, 2);
    chk("timeout R4 no byte", hs_tot - hs0, 0);
    chk("timeout R8 data idle", cfg_data_o, 0);
    @(posedge clk); #1 s_valid_i = 1'b0;
    stat_mode = 0;
    // release the model so the next run starts clean
    repeat (3) @(posedge clk);
  endtask

  task automatic t_nodone();
    int rs0;
    pay[0] = 8'h12; pay[1] = 8'hF0;
    rs0 = rise_tot;
    stat_mode = 0; cfg_done_i = 1'b0;
    pulse_start();
    feed(2, 1);
    wait_end();
    @(negedge clk);
    chk("nodone R6 fail", fail_o, 1);
    chk("nodone R6 err", err_o, 3);
    chk("nodone R6 no trailing", rise_tot - rs0, 16);
    chk("nodone R8 clk idle", cfg_clk_o, 0);
    chk("nodone R8 data idle", cfg_data_o, 0);
    repeat (5) @(negedge clk);
    chk("nodone R8 fail held", fail_o, 1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog R7 actual=hang expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_gaps_extra();
    t_start_ignored();
    t_nostat();
    t_timeout();
    t_nodone();
    pay[0] = 8'h01; pay[1] = 8'h80;
    run_ok(2, 3, "recover");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule